// File: doc/BRIEF.md
# ADC Register Front End with Prescaler, Completion Interrupt and Result Alignment

This block is the digital side of a 10-bit successive-approximation converter peripheral. It divides the system clock by a programmable factor to produce a one-cycle enable for the converter's bit clock. It latches each finished result and raises a completion flag that, when enabled, drives an interrupt request. The stored result is exposed to an 8-bit processor port as two read-only bytes, either right-justified or left-justified.

A converter model pulses `conv_done` for one cycle with `conv_result` valid. Software programs the control byte at address 0 and reads the result at addresses 1 (low) and 2 (high). In the control byte, bit 7 is the completion flag, bit 6 the interrupt enable, bit 5 the alignment select, bits 2:0 the prescaler select, and bits 4:3 read zero. The interrupt controller reports a taken vector with `irq_ack`, and `gie` is the global interrupt enable.

Top module: `adc_regif`

## Requirements
- R1: A one-cycle `conv_done` stores `conv_result` and sets the flag (control bit 7) at the same clock edge.
- R2: `irq` is high exactly one cycle after flag, enable (control bit 6) and `gie` are all high, and low otherwise.
- R3: `irq_ack` clears the flag.
- R4: Writing a control byte with bit 7 at 1 clears the flag, and bit 7 at 0 leaves it unchanged. Writing back a control byte that was read while the flag was set therefore clears it.
- R5: When a completion coincides with an acknowledge or a clearing write, the flag ends up set.
- R6: Select codes 0..7 give enable periods of 2, 2, 4, 8, 16, 32, 64 and 128 cycles, each pulse one cycle wide.
- R7: A control write that changes the select restarts the divider, so the first enable pulse comes exactly one period after the write edge.
- R8: With alignment 0, the high byte is {6'b0, result[9:8]} and the low byte is result[7:0].
- R9: With alignment 1, the high byte is result[9:2] and the low byte is {result[1:0], 6'b0}.
- R10: Changing the alignment bit reformats the stored result at once, with no new conversion.
- R11: After reset, the control byte, both data bytes, `irq` and `adc_clk_en` are zero.
- R12: Writes to addresses 1 and 2 do not change the data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 2 | Register address: 0 control, 1 data low, 2 data high |
| cpu_wr | input | 1 | Write strobe for `cpu_wdata` |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` |
| conv_done | input | 1 | One-cycle completion strobe from the converter |
| conv_result | input | 10 | Converter result, valid with `conv_done` |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt vector taken, clears the flag |
| adc_clk_en | output | 1 | One-cycle converter clock enable |
| irq | output | 1 | Completion interrupt request |

## Verification
The flag's set path and its two clear paths can collide on one edge. A completion may arrive in the same cycle as a vector acknowledge, or in the same cycle as a control write whose bit 7 is one. The bench drives `conv_done` together with `irq_ack`, and then together with such a write, on the same negative edge. It then reads the control byte and requires bit 7 to be set. The read-then-write-back sequence is checked as well, because there the clearing write carries a flag value that software only meant to preserve.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_DLO  = 2'd1,
    RA_DHI  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  localparam int unsigned FLAG_BIT  = 7;
  localparam int unsigned IE_BIT    = 6;
  localparam int unsigned ALIGN_BIT = 5;

  typedef struct packed {
    logic       ie;
    logic       align;
    logic [2:0] sel;
  } ctrl_t;

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  output logic             clk_en
);

  logic [CNT_W:0]   div_w;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;

  // code 0 repeats divide-by-2, otherwise divide by 2**sel
  always_comb begin
    if (sel == '0) div_w = (CNT_W+1)'(2);
    else           div_w = (CNT_W+1)'(1) << sel;
    limit = CNT_W'(div_w - (CNT_W+1)'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (cnt_q == limit) begin
      cnt_q <= '0;
      en_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      en_q  <= 1'b0;
    end
  end

  assign clk_en = en_q;

endmodule

// File: rtl/adc_irq_flag.sv
module adc_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic ack,
  input  logic w1c,
  input  logic ie,
  input  logic gie,
  output logic flag,
  output logic irq
);

  logic flag_q;
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      // a completion outranks any clear in the same cycle
      if (set)             flag_q <= 1'b1;
      else if (ack || w1c) flag_q <= 1'b0;
      irq_q <= flag_q && ie && gie;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;

endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W,
  localparam int unsigned PAD_W  = WORD_W - RES_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [RES_W-1:0]  din,
  input  logic              align,
  output logic [RES_W-1:0]  stored,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi
);

  logic [RES_W-1:0]  res_q;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk) begin
    if (rst)       res_q <= '0;
    else if (load) res_q <= din;
  end

  // formatting is applied on read, so an alignment change needs no new sample
  always_comb begin
    if (align) word = {res_q, {PAD_W{1'b0}}};
    else       word = {{PAD_W{1'b0}}, res_q};
  end

  assign stored = res_q;
  assign lo     = word[BYTE_W-1:0];
  assign hi     = word[WORD_W-1:BYTE_W];

endmodule

// File: rtl/adc_regif.sv
module adc_regif
  import adc_regif_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cpu_addr,
  input  logic              cpu_wr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  input  logic              gie,
  input  logic              irq_ack,
  output logic              adc_clk_en,
  output logic              irq
);

  ctrl_t             ctrl_q;
  logic              wr_ctrl;
  logic              w1c;
  logic              sel_change;
  logic              flag_q;
  logic              ie_w;
  logic              align_w;
  logic [RES_W-1:0]  res_q;
  logic [BYTE_W-1:0] lo_byte;
  logic [BYTE_W-1:0] hi_byte;
  logic              unused_wbits;

  assign wr_ctrl    = cpu_wr && (reg_addr_e'(cpu_addr) == RA_CTRL);
  assign w1c        = wr_ctrl && cpu_wdata[FLAG_BIT];
  assign sel_change = wr_ctrl && (cpu_wdata[SEL_W-1:0] != ctrl_q.sel);
  assign unused_wbits = ^cpu_wdata[ALIGN_BIT-1:SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.ie    <= cpu_wdata[IE_BIT];
      ctrl_q.align <= cpu_wdata[ALIGN_BIT];
      ctrl_q.sel   <= cpu_wdata[SEL_W-1:0];
    end
  end

  assign ie_w    = ctrl_q.ie;
  assign align_w = ctrl_q.align;

  adc_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .sel     (ctrl_q.sel),
    .restart (sel_change),
    .clk_en  (adc_clk_en)
  );

  adc_irq_flag u_flag (
    .clk  (clk),
    .rst  (rst),
    .set  (conv_done),
    .ack  (irq_ack),
    .w1c  (w1c),
    .ie   (ie_w),
    .gie  (gie),
    .flag (flag_q),
    .irq  (irq)
  );

  adc_result_fmt #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
    .clk    (clk),
    .rst    (rst),
    .load   (conv_done),
    .din    (conv_result),
    .align  (align_w),
    .stored (res_q),
    .lo     (lo_byte),
    .hi     (hi_byte)
  );

  always_comb begin
    cpu_rdata = '0;
    unique case (reg_addr_e'(cpu_addr))
      RA_CTRL: begin
        cpu_rdata[FLAG_BIT]    = flag_q;
        cpu_rdata[IE_BIT]      = ctrl_q.ie;
        cpu_rdata[ALIGN_BIT]   = ctrl_q.align;
        cpu_rdata[SEL_W-1:0]   = ctrl_q.sel;
      end
      RA_DLO:  cpu_rdata = lo_byte;
      RA_DHI:  cpu_rdata = hi_byte;
      RA_NONE: cpu_rdata = '0;
    endcase
  end

endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PAD_W = 2 * BYTE_W - RES_W
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_done,
  input logic [RES_W-1:0]  conv_result,
  input logic              irq_ack,
  input logic              gie,
  input logic              irq,
  input logic              adc_clk_en,
  input logic              flag,
  input logic              ie,
  input logic              align,
  input logic [RES_W-1:0]  res_q,
  input logic [BYTE_W-1:0] lo,
  input logic [BYTE_W-1:0] hi
);

  localparam logic [BYTE_W-1:0] PAD_MASK = BYTE_W'((1 << PAD_W) - 1);

  a_r1_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> flag);

  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> (res_q == $past(conv_result)));

  a_r2_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag && ie && gie));

  a_r2_irq_raised: assert property (@(posedge clk) disable iff (rst)
    (flag && ie && gie) |=> irq);

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !conv_done) |=> !flag);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    adc_clk_en |=> !adc_clk_en);

  a_r8_right_pad: assert property (@(posedge clk) disable iff (rst)
    !align |-> ((hi >> (RES_W - BYTE_W)) == '0));

  a_r9_left_pad: assert property (@(posedge clk) disable iff (rst)
    align |-> ((lo & PAD_MASK) == '0));

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> $stable(res_q));

endmodule

bind adc_regif adc_regif_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .conv_done   (conv_done),
  .conv_result (conv_result),
  .irq_ack     (irq_ack),
  .gie         (gie),
  .irq         (irq),
  .adc_clk_en  (adc_clk_en),
  .flag        (flag_q),
  .ie          (ie_w),
  .align       (align_w),
  .res_q       (res_q),
  .lo          (lo_byte),
  .hi          (hi_byte)
);

// File: tb/adc_regif_bench.sv
module adc_regif_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cpu_addr = 2'd0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       conv_done = 1'b0;
  logic [9:0] conv_result = 10'h000;
  logic       gie = 1'b0;
  logic       irq_ack = 1'b0;
  logic       adc_clk_en;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  adc_regif u_adc_regif (
    .clk (clk), .rst (rst), .cpu_addr (cpu_addr), .cpu_wr (cpu_wr),
    .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata), .conv_done (conv_done),
    .conv_result (conv_result), .gie (gie), .irq_ack (irq_ack),
    .adc_clk_en (adc_clk_en), .irq (irq)
  );

  // {align, result, expected low byte, expected high byte}
  localparam logic [26:0] VEC [10] = '{
    {1'b0, 10'h3FF, 8'hFF, 8'h03},
    {1'b1, 10'h3FF, 8'hC0, 8'hFF},
    {1'b0, 10'h2A5, 8'hA5, 8'h02},
    {1'b1, 10'h2A5, 8'h40, 8'hA9},
    {1'b0, 10'h001, 8'h01, 8'h00},
    {1'b1, 10'h001, 8'h40, 8'h00},
    {1'b0, 10'h200, 8'h00, 8'h02},
    {1'b1, 10'h200, 8'h00, 8'h80},
    {1'b0, 10'h155, 8'h55, 8'h01},
    {1'b1, 10'h155, 8'h40, 8'h55}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic convert(input logic [9:0] r);
    @(negedge clk);
    conv_done = 1'b1; conv_result = r;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R11: reset state
    #1 check("R11 irq", int'(irq), 0);
    check("R11 clk_en", int'(adc_clk_en), 0);
    rd_reg(2'd0, v); check("R11 ctrl", int'(v), 0);
    rd_reg(2'd1, v); check("R11 data low", int'(v), 0);
    rd_reg(2'd2, v); check("R11 data high", int'(v), 0);

    // R8 / R9: table of alignments and results
    for (int i = 0; i < 10; i++) begin
      wr_reg(2'd0, {2'b00, VEC[i][26], 5'b00001});
      convert(VEC[i][25:16]);
      rd_reg(2'd1, v);
      check(VEC[i][26] ? "R9 low byte" : "R8 low byte", int'(v), int'(VEC[i][15:8]));
      rd_reg(2'd2, v);
      check(VEC[i][26] ? "R9 high byte" : "R8 high byte", int'(v), int'(VEC[i][7:0]));
    end

    // R6 / R7: every divider setting, first pulse after the write and next period
    for (int s = 0; s < 8; s++) begin
      int div;
      int first;
      int gap;
      div = (s == 0) ? 2 : (1 << s);
      wr_reg(2'd0, 8'(s));
      first = 0;
      for (int k = 1; k <= 130 && first == 0; k++) begin
        @(negedge clk);
        if (adc_clk_en) first = k;
      end
      check("R7 first pulse after select change", first, div);
      gap = 0;
      for (int k = 1; k <= 130 && gap == 0; k++) begin
        @(negedge clk);
        if (adc_clk_en) gap = k;
      end
      check("R6 enable period", gap, div);
    end

    // clear any flag left by the table, then enable interrupts
    wr_reg(2'd0, 8'hC1);
    gie = 1'b1;

    // R1 / R2: completion raises flag and request
    convert(10'h0AB);
    rd_reg(2'd0, v);
    check("R1 flag set on completion", int'(v[7]), 1);
    @(negedge clk);
    check("R2 irq with all enables", int'(irq), 1);
    gie = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 irq blocked by gie", int'(irq), 0);
    gie = 1'b1;
    wr_reg(2'd0, 8'h01);
    repeat (2) @(negedge clk);
    check("R2 irq blocked by local enable", int'(irq), 0);
    wr_reg(2'd0, 8'h41);
    repeat (2) @(negedge clk);
    check("R2 irq with local enable restored", int'(irq), 1);

    // R3: acknowledge clears
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    rd_reg(2'd0, v);
    check("R3 flag after ack", int'(v[7]), 0);
    @(negedge clk);
    check("R3 irq after ack", int'(irq), 0);

    // R4: write zero keeps, read-modify-write clears
    convert(10'h123);
    wr_reg(2'd0, 8'h41);
    rd_reg(2'd0, v);
    check("R4 write zero keeps flag", int'(v[7]), 1);
    wr_reg(2'd0, v);
    rd_reg(2'd0, v);
    check("R4 read-modify-write clears flag", int'(v[7]), 0);
    repeat (2) @(negedge clk);
    check("R4 irq dropped after write-one", int'(irq), 0);

    // R5: completion coincides with acknowledge, then with write-one
    @(negedge clk);
    conv_done = 1'b1; conv_result = 10'h2A5; irq_ack = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; irq_ack = 1'b0;
    rd_reg(2'd0, v);
    check("R5 set beats ack", int'(v[7]), 1);
    wr_reg(2'd0, 8'hC1);
    @(negedge clk);
    conv_done = 1'b1; conv_result = 10'h2A5;
    cpu_addr = 2'd0; cpu_wdata = 8'hC1; cpu_wr = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; cpu_wr = 1'b0;
    rd_reg(2'd0, v);
    check("R5 set beats write-one", int'(v[7]), 1);

    // R10: realign stored result without converting
    rd_reg(2'd2, v);
    check("R10 high byte right-justified", int'(v), 8'h02);
    wr_reg(2'd0, 8'h61);
    rd_reg(2'd2, v);
    check("R10 high byte after realign", int'(v), 8'hA9);
    rd_reg(2'd1, v);
    check("R10 low byte after realign", int'(v), 8'h40);

    // R12: data bytes ignore writes
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd2, 8'h00);
    rd_reg(2'd1, v);
    check("R12 low byte read-only", int'(v), 8'h40);
    rd_reg(2'd2, v);
    check("R12 high byte read-only", int'(v), 8'hA9);

    summary();
    $finish;
  end

endmodule